// File: doc/BRIEF.md
# Synchronous Slave FIFO Write Master

This block streams 16-bit words from a local data source into the synchronous slave FIFO port of an external USB bridge. Data moves in fixed-length packets of `BURST_LEN` words (512 by default, 1024 bytes). The last word of each packet carries a packet-end strobe so the bridge commits the buffer at once. All bus outputs are registered and driven on the 50 MHz interface clock.

The bridge reports its state on two active-low flags: a full flag and a programmable almost-full flag. Each flag passes through one register stage before the control logic uses it. A new packet starts only when neither registered flag is asserted. Once a packet has started it always runs to completion. The almost-full flag is watched for the whole packet. If it was seen at any time during the packet, the master goes back to waiting at the packet boundary. If it was not seen, the next packet follows with no gap cycle.

The bridge watermark must therefore leave room for the rest of a packet plus the flag pipeline. A completed-packet counter and a sticky overrun bit show how the link behaves. The overrun bit is set when a write is driven onto the bus while the raw full flag is asserted.

Top module: `sfifo_wr_master`

## Requirements
- R1: Each packet is `BURST_LEN` bus writes. The words carry the accepted source words in acceptance order, with none lost or repeated. A word accepted at a clock edge is on the bus, with write strobe low, for the cycle that follows that edge.
- R2: Packet end (active low) is driven low together with the write strobe on the last word of each packet. It is high on every other cycle.
- R3: While the registered full flag shows full (`full_flag_ni` low), no packet is started and `src_ready_o` stays low. A packet already in progress completes.
- R4: When a packet completes and the almost-full flag was not seen during it, the next packet starts on the following cycle. Back-to-back source words then stream with no gap at the packet boundary.
- R5: If the registered almost-full flag (`part_flag_ni` low) is seen at any point during a packet, that packet completes. No further packet starts until both flags are clear.
- R6: `src_ready_o` is high only while a packet is in progress. A source stall (`src_valid_i` low) leaves the write strobe and chip select high for that cycle. Chip select is low exactly when the write strobe is low.
- R7: `burst_count_o` increments by one for each completed packet and holds otherwise.
- R8: `overrun_o` sets when a bus write strobe is low at a clock edge while `full_flag_ni` is low. It stays set until reset.
- R9: While `rst_ni` is low, write strobe, packet end and chip select are high, `src_ready_o` is low, and `burst_count_o` and `overrun_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock (50 MHz) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_data_i | input | DATA_W | Source word |
| src_valid_i | input | 1 | Source word valid |
| src_ready_o | output | 1 | Master accepts a word this cycle |
| bus_data_o | output | DATA_W | FIFO data bus |
| bus_cs_no | output | 1 | Chip select, active low |
| bus_wr_no | output | 1 | Write strobe, active low |
| bus_pktend_no | output | 1 | Packet end, active low |
| full_flag_ni | input | 1 | Bridge full flag, active low |
| part_flag_ni | input | 1 | Bridge almost-full flag, active low |
| burst_count_o | output | CNT_W | Completed packets |
| overrun_o | output | 1 | Sticky write-while-full indicator |

## Verification
The streaming path is driven with several source patterns:
- A steady full-rate stream shows that packets run back to back with no gap.
- Alternating and sparse valid masks show that stalls neither drop nor duplicate words, and that packet end still lands on the last word.
- An irregular mask mixes short and long stalls.

The almost-full flag is raised early in the first packet and again inside a later packet. This separates "finish the current packet and stop" from both "stop at once" and "ignore the flag". Directed cases hold the full flag from reset, to show that no packet starts while it is asserted. They also drop the full flag during a packet, to show that the packet completes, the overrun bit sets and stays set, and reset clears it.

// File: rtl/sfw_pkg.sv
package sfw_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_BURST = 1'b1
  } sfw_state_e;
endpackage

// File: rtl/sfw_flag_stage.sv
// One register stage per active-low flag; outputs are active high.
module sfw_flag_stage #(
  parameter int unsigned NUM_FLAGS = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_FLAGS-1:0] flags_ni,
  output logic [NUM_FLAGS-1:0] flags_o
);
  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    logic flag_q;
    // reset to asserted so nothing starts before a real sample arrives
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= 1'b1;
      else         flag_q <= ~flags_ni[g];
    end
    assign flags_o[g] = flag_q;
  end
endmodule

// File: rtl/sfw_beat_counter.sv
module sfw_beat_counter #(
  parameter int unsigned BURST_LEN = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  output logic last_o
);
  localparam int unsigned BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

  logic [BEAT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (step_i && last_o)   cnt_q <= '0;
    else if (step_i)             cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == LAST_BEAT);

  assert_beat_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST_BEAT);

  assert_wrap_after_last_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && last_o && !clr_i) |=> (cnt_q == '0));
endmodule

// File: rtl/sfw_ctrl.sv
module sfw_ctrl
  import sfw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic full_i,
  input  logic part_i,
  input  logic src_valid_i,
  input  logic last_i,
  output logic src_ready_o,
  output logic fire_o,
  output logic clr_cnt_o
);
  sfw_state_e state_q, state_d;
  logic       part_seen_q, part_seen_d;
  logic       done;

  assign src_ready_o = (state_q == ST_BURST);
  assign fire_o      = src_ready_o && src_valid_i;
  assign done        = fire_o && last_i;
  assign clr_cnt_o   = (state_q == ST_IDLE);

  always_comb begin
    state_d     = state_q;
    part_seen_d = part_seen_q;
    unique case (state_q)
      ST_IDLE: begin
        part_seen_d = 1'b0;
        if (!full_i && !part_i) state_d = ST_BURST;
      end
      ST_BURST: begin
        if (part_i) part_seen_d = 1'b1;
        if (done) begin
          part_seen_d = 1'b0;
          // the burst in flight always finishes; decide only at its end
          if (part_seen_q || part_i || full_i) state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      part_seen_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      part_seen_q <= part_seen_d;
    end
  end

  assert_no_start_when_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && full_i) |=> (state_q == ST_IDLE));

  assert_no_start_when_part_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && part_i) |=> (state_q == ST_IDLE));

  assert_stop_after_part_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && (part_seen_q || part_i)) |=> (state_q == ST_IDLE));

  assert_back_to_back_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !part_seen_q && !part_i && !full_i) |=> src_ready_o);

  assert_burst_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_ready_o && !done) |=> src_ready_o);
endmodule

// File: rtl/sfw_bus_reg.sv
module sfw_bus_reg #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic              last_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              full_raw_ni,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_cs_no,
  output logic              bus_wr_no,
  output logic              bus_pktend_no,
  output logic [CNT_W-1:0]  burst_count_o,
  output logic              overrun_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_data_o    <= '0;
      bus_cs_no     <= 1'b1;
      bus_wr_no     <= 1'b1;
      bus_pktend_no <= 1'b1;
    end else begin
      bus_cs_no     <= ~fire_i;
      bus_wr_no     <= ~fire_i;
      bus_pktend_no <= ~(fire_i && last_i);
      if (fire_i) bus_data_o <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               burst_count_o <= '0;
    else if (fire_i && last_i) burst_count_o <= burst_count_o + 1'b1;
  end

  // write seen on the bus while the bridge reports full
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          overrun_o <= 1'b0;
    else if (!bus_wr_no && !full_raw_ni)  overrun_o <= 1'b1;
  end

  assert_overrun_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);

  assert_pktend_needs_wr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_pktend_no |-> !bus_wr_no);

  assert_cs_tracks_wr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_cs_no == bus_wr_no);
endmodule

// File: rtl/sfifo_wr_master.sv
module sfifo_wr_master #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned BURST_LEN = 512,
  parameter int unsigned CNT_W     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] src_data_i,
  input  logic              src_valid_i,
  output logic              src_ready_o,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_cs_no,
  output logic              bus_wr_no,
  output logic              bus_pktend_no,
  input  logic              full_flag_ni,
  input  logic              part_flag_ni,
  output logic [CNT_W-1:0]  burst_count_o,
  output logic              overrun_o
);
  localparam int unsigned FLAG_FULL = 0;
  localparam int unsigned FLAG_PART = 1;

  logic [1:0] flags;
  logic       fire, last, clr_cnt;

  sfw_flag_stage #(.NUM_FLAGS(2)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flags_ni ({part_flag_ni, full_flag_ni}),
    .flags_o  (flags)
  );

  sfw_beat_counter #(.BURST_LEN(BURST_LEN)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_cnt),
    .step_i (fire),
    .last_o (last)
  );

  sfw_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .full_i      (flags[FLAG_FULL]),
    .part_i      (flags[FLAG_PART]),
    .src_valid_i (src_valid_i),
    .last_i      (last),
    .src_ready_o (src_ready_o),
    .fire_o      (fire),
    .clr_cnt_o   (clr_cnt)
  );

  sfw_bus_reg #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_bus (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fire_i        (fire),
    .last_i        (last),
    .data_i        (src_data_i),
    .full_raw_ni   (full_flag_ni),
    .bus_data_o    (bus_data_o),
    .bus_cs_no     (bus_cs_no),
    .bus_wr_no     (bus_wr_no),
    .bus_pktend_no (bus_pktend_no),
    .burst_count_o (burst_count_o),
    .overrun_o     (overrun_o)
  );

  assert_accept_to_bus_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_valid_i && src_ready_o) |=> (!bus_wr_no && bus_data_o == $past(src_data_i)));

  assert_stall_no_wr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(src_valid_i && src_ready_o) |=> bus_wr_no);

  assert_last_has_pktend_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && last) |=> !bus_pktend_no);

  assert_count_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && last) |=> (burst_count_o == $past(burst_count_o) + 1'b1));

  assert_count_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fire && last) |=> $stable(burst_count_o));
endmodule

// File: tb/sim_sfifo_wr_master.sv
module sim_sfifo_wr_master;
  localparam int BL     = 8;
  localparam int DW     = 16;
  localparam int CW     = 16;
  localparam int NVEC   = 6;
  localparam int NO_PART = 255;

  // per scenario: valid mask (bit i = cycle i mod 8), words offered,
  // word index at which almost-full is raised, words expected on the bus
  localparam logic [7:0] V_MASK [NVEC] = '{8'hFF, 8'h55, 8'hFF, 8'hFF, 8'h11, 8'hB7};
  localparam int         V_NW   [NVEC] = '{24, 16, 24, 24, 8, 32};
  localparam int         V_PART [NVEC] = '{NO_PART, NO_PART, 2, 10, NO_PART, NO_PART};
  localparam int         V_EXP  [NVEC] = '{24, 16, 8, 16, 8, 32};

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [DW-1:0] src_data_i = '0;
  logic          src_valid_i = 1'b0;
  logic          src_ready_o;
  logic [DW-1:0] bus_data_o;
  logic          bus_cs_no, bus_wr_no, bus_pktend_no;
  logic          full_flag_ni = 1'b1;
  logic          part_flag_ni = 1'b1;
  logic [CW-1:0] burst_count_o;
  logic          overrun_o;

  int n_chk = 0, n_fail = 0;
  int mon_chk = 0, mon_fail = 0;
  int words_rx = 0;
  logic [DW-1:0] seq_tx = 16'h1000;

  always #10 clk_i = ~clk_i;

  sfifo_wr_master #(.DATA_W(DW), .BURST_LEN(BL), .CNT_W(CW)) u0 (
    .clk_i, .rst_ni, .src_data_i, .src_valid_i, .src_ready_o,
    .bus_data_o, .bus_cs_no, .bus_wr_no, .bus_pktend_no,
    .full_flag_ni, .part_flag_ni, .burst_count_o, .overrun_o
  );

  // bus monitor: data order (R1), packet end placement (R2), chip select (R6)
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      words_rx = 0;
    end else begin
      mon_chk++;
      if (bus_cs_no != bus_wr_no) begin
        mon_fail++;
        $display("FAIL R6 cs_n=%0b expected wr_n=%0b", bus_cs_no, bus_wr_no);
      end
      if (!bus_wr_no) begin
        mon_chk += 2;
        if (bus_data_o != 16'h1000 + DW'(words_rx)) begin
          mon_fail++;
          $display("FAIL R1 data=%h expected %h", bus_data_o, 16'h1000 + DW'(words_rx));
        end
        if (bus_pktend_no != ((words_rx % BL) != BL - 1)) begin
          mon_fail++;
          $display("FAIL R2 pktend_n=%0b expected %0b at word %0d",
                   bus_pktend_no, (words_rx % BL) != BL - 1, words_rx);
        end
        words_rx++;
      end else begin
        mon_chk++;
        if (!bus_pktend_no) begin
          mon_fail++;
          $display("FAIL R2 pktend_n=0 expected 1 without write");
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk_i);
    #5;
  endtask

  // offers nw words under a valid mask; optional flag drop at word index
  task automatic stream(input logic [7:0] mask, input int nw, input int part_at,
                        input int full_at, input int cycles);
    int sent = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk_i);
      src_valid_i  = mask[c % 8] && (sent < nw);
      src_data_i   = seq_tx;
      part_flag_ni = !(part_at != NO_PART && sent >= part_at);
      full_flag_ni = !(full_at != NO_PART && sent >= full_at);
      @(posedge clk_i);
      if (src_valid_i && src_ready_o) begin
        sent++;
        seq_tx++;
      end
    end
    @(negedge clk_i);
    src_valid_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    seq_tx = 16'h1000;
    repeat (3) @(negedge clk_i);
    // R9: values held while reset is active
    chk(bus_wr_no && bus_pktend_no && bus_cs_no, "R9 strobes idle in reset",
        {bus_wr_no, bus_pktend_no, bus_cs_no}, 7);
    chk(!src_ready_o, "R9 src_ready low in reset", src_ready_o, 0);
    chk(burst_count_o == 0 && !overrun_o, "R9 count/overrun clear in reset",
        burst_count_o + overrun_o, 0);
    rst_ni = 1'b1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk + mon_chk + 1,
             n_fail + mon_fail + 1);
    $finish;
  end

  initial begin
    int base;
    full_flag_ni = 1'b0;
    do_reset();

    // R3: full held from reset, source offering data
    @(negedge clk_i);
    src_valid_i = 1'b1;
    src_data_i  = seq_tx;
    settle(20);
    chk(words_rx == 0, "R3 no write while full", words_rx, 0);
    chk(!src_ready_o, "R3 ready low while full", src_ready_o, 0);
    @(negedge clk_i);
    src_valid_i = 1'b0;
    stream(8'hFF, BL, NO_PART, NO_PART, BL * 4 + 10);
    settle(2);
    chk(words_rx == BL, "R3 burst after full clears", words_rx, BL);
    chk(burst_count_o == 1, "R7 one burst counted", burst_count_o, 1);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      base = words_rx;
      stream(V_MASK[v], V_NW[v], V_PART[v], NO_PART, V_NW[v] * 10 + 40);
      settle(3);
      chk(words_rx - base == V_EXP[v],
          (V_PART[v] != NO_PART) ? "R5 words before stop" : "R1 words streamed",
          words_rx - base, V_EXP[v]);
      chk(burst_count_o == words_rx / BL, "R7 burst count", burst_count_o, words_rx / BL);
      // R5: almost-full released, so no further stall remains
      @(negedge clk_i);
      part_flag_ni = 1'b1;
      settle(3);
      chk(src_ready_o, "R5 resumes after flag clears", src_ready_o, 1);
    end

    // R4: gapless boundary at full rate
    begin
      int first_c = -1, last_c = -1, c = 0;
      base = words_rx;
      fork
        stream(8'hFF, 2 * BL, NO_PART, NO_PART, 2 * BL + 10);
        begin
          for (int k = 0; k < 2 * BL + 10; k++) begin
            @(negedge clk_i); #1;
            if (!bus_wr_no) begin
              if (first_c < 0) first_c = c;
              last_c = c;
            end
            c++;
          end
        end
      join
      chk(last_c - first_c == 2 * BL - 1, "R4 no gap across boundary",
          last_c - first_c, 2 * BL - 1);
      settle(2);
      chk(words_rx - base == 2 * BL, "R4 two bursts streamed", words_rx - base, 2 * BL);
    end

    // R8: full dropped mid-burst; burst completes, overrun sticks
    chk(!overrun_o, "R8 overrun clear before", overrun_o, 1'b0);
    base = words_rx;
    stream(8'hFF, BL, NO_PART, 3, BL * 3 + 10);
    settle(2);
    chk(words_rx - base == BL, "R3 in-flight burst completes", words_rx - base, BL);
    chk(overrun_o, "R8 overrun set", overrun_o, 1);
    @(negedge clk_i);
    full_flag_ni = 1'b1;
    settle(10);
    chk(overrun_o, "R8 overrun sticky", overrun_o, 1);

    // R6: stalled source with ready high leaves the bus quiet
    chk(src_ready_o, "R6 ready high in burst", src_ready_o, 1);
    base = words_rx;
    settle(6);
    chk(words_rx == base && bus_wr_no, "R6 no write during stall", words_rx - base, 0);

    do_reset();
    settle(2);
    chk(!overrun_o && burst_count_o == 0, "R9 cleared after reset",
        overrun_o + burst_count_o, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk + mon_chk,
             n_fail + mon_fail);
    $finish;
  end
endmodule